// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit sits beside a flash program/erase engine and turns that engine's single-cycle event pulses into sticky raw status bits. Each raw bit stays set until software clears it. The raw bits are ANDed with a software-written enable mask. A single interrupt line to the system interrupt controller is raised whenever any enabled bit is set.

Software reaches the unit through a small synchronous register port with four word addresses:

| Address | Access | Contents |
|---|---|---|
| 0 | read-only | raw status |
| 1 | read/write | enable mask |
| 2 | read-only | masked status |
| 3 | write-only | write-1-to-clear |

The unit also looks at every word just before it is programmed. It compares the requested word with the word already stored. It flags the request when that request would need a stored 0 to become a 1, which a program operation cannot do.

Top module: `flash_irq_status`

## Requirements
- R1: After synchronous reset, raw status, enable mask, masked status and `irq_o` are all 0.
- R2: A one-cycle high pulse on an event input sets its raw bit on that clock edge, and the bit stays set afterwards. The bit positions are:

  | Input | Raw bit |
  |---|---|
  | `ev_access_i` | 0 |
  | `ev_done_i` | 1 |
  | `ev_eeprom_i` | 2 |
  | `ev_pump_i` | 9 |
  | invalid data | 10 |
  | `ev_erase_fail_i` | 11 |
  | `ev_prog_fail_i` | 13 |

- R3: Bits 3–8, 12 and 14–31 read as 0 at addresses 0, 1 and 2, even after all ones are written to the mask at address 1.
- R4: Writing a word to address 3 clears each raw bit whose position holds a 1 in that word. Positions holding 0 leave their raw bit unchanged.
- R5: Writes to address 0 or address 2 change neither raw status nor mask.
- R6: When `chk_valid_i` is high and `(~chk_stored_i & chk_req_i)` is nonzero, raw bit 10 is set on that edge. A request whose 1s are all already 1 in the stored word does not set bit 10.
- R7: Reading address 2 returns raw status ANDed with the mask.
- R8: `irq_o` is 1 exactly when at least one bit of masked status is 1.
- R9: When a set event and a clear write for the same bit fall on the same edge, the bit ends up set.
- R10: Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_access_i | input | 1 | Protection violation pulse |
| ev_done_i | input | 1 | Program/erase cycle complete pulse |
| ev_eeprom_i | input | 1 | EEPROM event pulse |
| ev_pump_i | input | 1 | Pump voltage out of range, operation aborted |
| ev_erase_fail_i | input | 1 | Erase verify failure pulse |
| ev_prog_fail_i | input | 1 | Program verify failure pulse |
| chk_valid_i | input | 1 | Program word check strobe |
| chk_stored_i | input | DATA_W | Word currently stored at the target |
| chk_req_i | input | DATA_W | Word requested to be programmed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Interrupt request to controller |

## Verification
On every cycle, the assertions check:
- that an event or an overwrite request sets its raw bit on the next edge;
- that a raw bit only falls after a matching clear write;
- that reserved bits stay 0;
- that the interrupt line follows the masked status.

The bench's scenarios are needed for the rest:
- reset values;
- that zeros in a clear word leave bits alone;
- that writes to the read-only addresses are ignored;
- the same-edge set-versus-clear case;
- the full read mux across random mixes of events, masks and clears.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int REG_W = 32;
    localparam int ADR_W = 2;

    localparam int B_ACCESS     = 0;
    localparam int B_DONE       = 1;
    localparam int B_EEPROM     = 2;
    localparam int B_PUMP       = 9;
    localparam int B_BAD_DATA   = 10;
    localparam int B_ERASE_FAIL = 11;
    localparam int B_PROG_FAIL  = 13;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << B_ACCESS)   | (REG_W'(1) << B_DONE)       |
        (REG_W'(1) << B_EEPROM)   | (REG_W'(1) << B_PUMP)       |
        (REG_W'(1) << B_BAD_DATA) | (REG_W'(1) << B_ERASE_FAIL) |
        (REG_W'(1) << B_PROG_FAIL);

    typedef enum logic [ADR_W-1:0] {
        A_RAW    = 2'd0,
        A_MASK   = 2'd1,
        A_MASKED = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic prog_fail;
        logic erase_fail;
        logic bad_data;
        logic pump;
        logic eeprom;
        logic done;
        logic access;
    } evt_t;

    typedef struct packed {
        logic             wr;
        reg_addr_e        addr;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [REG_W-1:0] evt_to_vec(evt_t e);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_ACCESS]     = e.access;
        v[B_DONE]       = e.done;
        v[B_EEPROM]     = e.eeprom;
        v[B_PUMP]       = e.pump;
        v[B_BAD_DATA]   = e.bad_data;
        v[B_ERASE_FAIL] = e.erase_fail;
        v[B_PROG_FAIL]  = e.prog_fail;
        return v;
    endfunction

endpackage

// File: rtl/fis_overwrite_check.sv
module fis_overwrite_check #(
    parameter int DATA_W = 32
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] stored_i,
    input  logic [DATA_W-1:0] req_i,
    output logic              bad_o
);
    logic [DATA_W-1:0] rise_bits;

    always_comb begin
        rise_bits = ~stored_i & req_i;
        bad_o     = valid_i & (|rise_bits);
    end
endmodule

// File: rtl/fis_raw_status.sv
module fis_raw_status
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] raw_o
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (set_i[b]) q <= 1'b1;
                else if (clr_i[b]) q <= 1'b0;
            end
            assign raw_o[b] = q;
        end else begin : g_rsv
            assign raw_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/fis_reg_if.sv
module fis_reg_if
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req_i,
    input  logic [REG_W-1:0] raw_i,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] clr_o,
    output logic [REG_W-1:0] masked_o,
    output logic [REG_W-1:0] rdata_o
);
    logic [REG_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (req_i.wr && req_i.addr == A_MASK)
            mask_q <= req_i.wdata & IMPL_MASK;
    end

    always_comb begin
        mask_o   = mask_q;
        masked_o = raw_i & mask_q;
        clr_o    = (req_i.wr && req_i.addr == A_CLEAR) ? (req_i.wdata & IMPL_MASK) : '0;
        unique case (req_i.addr)
            A_RAW:    rdata_o = raw_i;
            A_MASK:   rdata_o = mask_q;
            A_MASKED: rdata_o = masked_o;
            A_CLEAR:  rdata_o = '0;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
    import flash_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_access_i,
    input  logic              ev_done_i,
    input  logic              ev_eeprom_i,
    input  logic              ev_pump_i,
    input  logic              ev_erase_fail_i,
    input  logic              ev_prog_fail_i,
    input  logic              chk_valid_i,
    input  logic [DATA_W-1:0] chk_stored_i,
    input  logic [DATA_W-1:0] chk_req_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    evt_t             evt;
    reg_req_t         req;
    logic             bad_data;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] raw_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] masked;

    fis_overwrite_check #(.DATA_W(DATA_W)) u_ovw (
        .valid_i  (chk_valid_i),
        .stored_i (chk_stored_i),
        .req_i    (chk_req_i),
        .bad_o    (bad_data)
    );

    always_comb begin
        evt.access     = ev_access_i;
        evt.done       = ev_done_i;
        evt.eeprom     = ev_eeprom_i;
        evt.pump       = ev_pump_i;
        evt.bad_data   = bad_data;
        evt.erase_fail = ev_erase_fail_i;
        evt.prog_fail  = ev_prog_fail_i;
        set_vec        = evt_to_vec(evt);
        req.wr         = reg_wr_i;
        req.addr       = reg_addr_e'(reg_addr_i);
        req.wdata      = reg_wdata_i;
    end

    fis_raw_status u_raw (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .raw_o (raw_q)
    );

    fis_reg_if u_regs (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .raw_i    (raw_q),
        .mask_o   (mask_q),
        .clr_o    (clr_vec),
        .masked_o (masked),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = |masked;
endmodule

// File: rtl/fis_checker.sv
module fis_checker
    import flash_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_access_i,
    input logic              ev_done_i,
    input logic              chk_valid_i,
    input logic [DATA_W-1:0] chk_stored_i,
    input logic [DATA_W-1:0] chk_req_i,
    input logic              reg_wr_i,
    input logic [1:0]        reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       reg_rdata_o,
    input logic [31:0]       raw_q,
    input logic [31:0]       mask_q,
    input logic              irq_o
);
    logic clr_wr;
    assign clr_wr = reg_wr_i && (reg_addr_i == 2'd3);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && mask_q == '0 && !irq_o));

    assert_done_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_done_i |=> raw_q[B_DONE]);

    assert_access_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_access_i |=> raw_q[B_ACCESS]);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o & ~IMPL_MASK) == '0);

    assert_clear_only_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(raw_q[B_DONE]) |-> $past(clr_wr && reg_wdata_i[B_DONE]));

    assert_bad_data_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_valid_i && |(~chk_stored_i & chk_req_i)) |=> raw_q[B_BAD_DATA]);

    assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(raw_q & mask_q));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_access_i && clr_wr && reg_wdata_i[B_ACCESS]) |=> raw_q[B_ACCESS]);
endmodule

bind flash_irq_status fis_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_access_i  (ev_access_i),
    .ev_done_i    (ev_done_i),
    .chk_valid_i  (chk_valid_i),
    .chk_stored_i (chk_stored_i),
    .chk_req_i    (chk_req_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .raw_q        (raw_q),
    .mask_q       (mask_q),
    .irq_o        (irq_o)
);

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam logic [31:0] IMPL = 32'h0000_2E07;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_access = 0, ev_done = 0, ev_eeprom = 0, ev_pump = 0;
    logic          ev_efail = 0, ev_pfail = 0;
    logic          chk_valid = 0;
    logic [DW-1:0] chk_stored = '0, chk_req = '0;
    logic          reg_wr = 0;
    logic [1:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_tests = 0, n_fail = 0;
    logic [31:0] m_raw = '0, m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_irq_status #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .ev_access_i(ev_access), .ev_done_i(ev_done), .ev_eeprom_i(ev_eeprom),
        .ev_pump_i(ev_pump), .ev_erase_fail_i(ev_efail), .ev_prog_fail_i(ev_pfail),
        .chk_valid_i(chk_valid), .chk_stored_i(chk_stored), .chk_req_i(chk_req),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    function automatic logic [31:0] set_vec_f();
        logic [31:0] v = '0;
        v[0]  = ev_access;
        v[1]  = ev_done;
        v[2]  = ev_eeprom;
        v[9]  = ev_pump;
        v[10] = chk_valid && ((~chk_stored & chk_req) != '0);
        v[11] = ev_efail;
        v[13] = ev_pfail;
        return v;
    endfunction

    function automatic logic [31:0] read_f(logic [1:0] a);
        case (a)
            2'd0:    return m_raw;
            2'd1:    return m_mask;
            2'd2:    return m_raw & m_mask;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {ev_access, ev_done, ev_eeprom, ev_pump, ev_efail, ev_pfail} = '0;
        chk_valid = 0;
        reg_wr    = 0;
    endtask

    // Inputs are already driven; take one edge, update the model, return at negedge.
    task automatic tick();
        logic [31:0] s, c;
        s = set_vec_f();
        c = (reg_wr && reg_addr == 2'd3) ? (reg_wdata & IMPL) : '0;
        @(posedge clk);
        if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata & IMPL;
        m_raw = s | (m_raw & ~c);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic rd(string req, logic [1:0] a);
        reg_addr = a;
        #1;
        check(req, reg_rdata, read_f(a));
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 each event sets its bit and stays
        ev_done = 1; tick(); tick();
        rd("R2 done", 2'd0);
        ev_access = 1; ev_eeprom = 1; ev_pump = 1; ev_efail = 1; ev_pfail = 1; tick();
        rd("R2 all", 2'd0);
        check("R2 value", reg_rdata, 32'h0000_2A07);

        // R3 reserved bits in mask
        wr(2'd1, 32'hFFFF_FFFF);
        rd("R3 mask", 2'd1);
        check("R3 mask value", reg_rdata, IMPL & ~32'h0);
        rd("R7 masked", 2'd2);
        #1 check("R8 irq", {31'd0, irq}, 32'd1);

        // R5 writes to read-only addresses ignored
        wr(2'd0, 32'h0); rd("R5 raw", 2'd0);
        wr(2'd2, 32'h0); rd("R5 mask", 2'd1);
        check("R5 raw kept", read_f(2'd0), 32'h0000_2A07);

        // R4 clear with zeros no effect, then selective clear
        wr(2'd3, 32'h0); rd("R4 zeros", 2'd0);
        check("R4 zeros val", reg_rdata, 32'h0000_2A07);
        wr(2'd3, 32'h0000_0202); rd("R4 partial", 2'd0);
        check("R4 partial val", reg_rdata, 32'h0000_2805);

        // R10 clear address reads 0
        rd("R10", 2'd3);

        // R9 set wins
        ev_done = 1; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 32'h2;
        tick();
        rd("R9", 2'd0);
        check("R9 bit", {31'd0, reg_rdata[1]}, 32'd1);

        // R6 invalid data
        wr(2'd3, 32'hFFFF_FFFF);
        chk_valid = 1; chk_stored = 32'hF0F0_F0F0; chk_req = 32'h3030_0000; tick();
        rd("R6 subset", 2'd0);
        check("R6 subset bit", {31'd0, reg_rdata[10]}, 32'd0);
        chk_valid = 0; chk_stored = 32'h0; chk_req = 32'h1; tick();
        rd("R6 no valid", 2'd0);
        chk_valid = 1; chk_stored = 32'hFFFF_FFFE; chk_req = 32'h0000_0001; tick();
        rd("R6 flag", 2'd0);
        check("R6 flag bit", {31'd0, reg_rdata[10]}, 32'd1);

        // R8 irq low when masked empty
        wr(2'd1, 32'h0);
        #1 check("R8 irq off", {31'd0, irq}, 32'd0);

        // random mix R2 R4 R7 R8 R9
        for (int i = 0; i < 3000; i++) begin
            ev_access = ($urandom % 8) == 0;
            ev_done   = ($urandom % 8) == 0;
            ev_eeprom = ($urandom % 8) == 0;
            ev_pump   = ($urandom % 8) == 0;
            ev_efail  = ($urandom % 8) == 0;
            ev_pfail  = ($urandom % 8) == 0;
            chk_valid = ($urandom % 4) == 0;
            chk_stored = $urandom | $urandom;
            chk_req    = $urandom & $urandom;
            reg_wr    = ($urandom % 2) == 0;
            reg_addr  = 2'($urandom);
            reg_wdata = $urandom;
            tick();
            rd("R7 random", 2'($urandom));
            check("R8 random", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule